// File: doc/BRIEF.md
# Streaming Displacement-Field Euler Updater

This block advances a three-dimensional displacement field by one explicit Euler step. The three displacement components and the three velocity components of every voxel arrive together as one stream, in raster order. The x index runs fastest, then y, then z. The block keeps the three most recent z-slices on chip. Every face neighbour a voxel needs is therefore read locally, and no voxel is fetched twice.

For each interior voxel the block forms central-difference gradients of the displacement. It applies the transport correction `v·∇u` to the velocity and adds the result, scaled by a constant timestep `dt`, to the old displacement. The new displacement voxels leave in raster order, two clock cycles after the input that completes their stencil. Voxels on the one-voxel border of the volume produce no output.

All values are signed fixed point, 32 bits wide with 10 fractional bits. `dt` is a plain input that the caller holds constant. The block computes no reduction over the volume.

Top module: `disp_euler_top`

## Requirements
- R1: Voxels enter with x fastest, then y, then z, over a volume of DIM_X by DIM_Y by DIM_Z. An output is produced only for centres with 1<=x<=DIM_X-2, 1<=y<=DIM_Y-2 and 1<=z<=DIM_Z-2. Outputs appear in raster order, exactly (DIM_X-2)*(DIM_Y-2)*(DIM_Z-2) per volume.
- R2: The output for centre (x,y,z) has out_valid high two clock cycles after the edge that accepts input voxel (x,y,z+1). The first output of a volume follows acceptance of voxel number 2*DIM_X*DIM_Y+DIM_X+1, counted from zero.
- R3: The gradient of component i along an axis is (u_i at +1 minus u_i at -1) shifted right arithmetically by one, which rounds toward minus infinity. The axes are x, y and z for velocity components 0, 1 and 2.
- R4: The rate of component i is R_i = v_i - (v0*gx_i + v1*gy_i + v2*gz_i). Each product is a 64-bit signed product shifted right arithmetically by 10 and truncated to 32 bits. Sums wrap at 32 bits.
- R5: The new value of component i is u_i + ((dt*R_i) >>> 10), truncated to 32 bits. dt is used in the cycle in which that output is registered.
- R6: With dt equal to zero, each output equals the old displacement of its centre voxel.
- R7: Slice storage rotates over three banks, and a new slice overwrites the oldest one. A volume with more than three slices yields correct results in every output slice.
- R8: While rst_n is low at a clock edge, out_valid and all out_u outputs are zero. After reset, the next accepted voxel is taken as (0,0,0).
- R9: Cycles with in_valid low change neither the results nor the voxel position, whatever data is on the inputs.
- R10: The voxel accepted after (DIM_X-1,DIM_Y-1,DIM_Z-1) is taken as (0,0,0) of a new volume, with no reset in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input voxel present this cycle |
| in_u0 | input | 32 | Displacement component 0 (x), Q10 |
| in_u1 | input | 32 | Displacement component 1 (y), Q10 |
| in_u2 | input | 32 | Displacement component 2 (z), Q10 |
| in_v0 | input | 32 | Velocity component 0 (x), Q10 |
| in_v1 | input | 32 | Velocity component 1 (y), Q10 |
| in_v2 | input | 32 | Velocity component 2 (z), Q10 |
| dt | input | 32 | Timestep constant, Q10 |
| out_valid | output | 1 | Updated voxel present this cycle |
| out_u0 | output | 32 | Updated displacement component 0, Q10 |
| out_u1 | output | 32 | Updated displacement component 1, Q10 |
| out_u2 | output | 32 | Updated displacement component 2, Q10 |

## Verification
The bench builds the block with a 4 by 4 by 5 volume. Five slices make the bank rotation wrap past its three banks, so the output slice at z=3 depends on a bank that has already been overwritten. A 4 by 4 slice leaves a 2 by 2 interior, which puts every centre next to the border. That exposes any mistake in neighbour addressing at the row and slice edges. The volume is small enough that every output voxel of every run is compared with an independent model, checked for its exact arrival cycle, and counted.

// File: rtl/disp_pkg.sv
// Package of shared fixed-point types and arithmetic helpers for the
// displacement updater. Assumes signed two's complement, DATA_W bits wide,
// FRAC_W fractional bits.
package disp_pkg;
    parameter int DATA_W = 32;
    parameter int FRAC_W = 10;

    typedef logic signed [DATA_W-1:0] fx_t;
    typedef logic [2:0][DATA_W-1:0]   vec_t;

    // One stored voxel: displacement and velocity
    typedef struct packed {
        vec_t u;
        vec_t v;
    } cell_t;

    // Stencil taps of one centre voxel
    typedef struct packed {
        vec_t c;
        vec_t xp;
        vec_t xm;
        vec_t yp;
        vec_t ym;
        vec_t zp;
        vec_t zm;
        vec_t vc;
    } taps_t;

    // Fixed-point multiply: full product, arithmetic shift, truncate
    function automatic fx_t fx_mul(input fx_t a, input fx_t b);
        logic signed [2*DATA_W-1:0] p;
        p = $signed({{DATA_W{a[DATA_W-1]}}, a}) * $signed({{DATA_W{b[DATA_W-1]}}, b});
        return p[FRAC_W+DATA_W-1:FRAC_W];
    endfunction

    // Central difference halved with floor rounding
    function automatic fx_t half_diff(input fx_t p, input fx_t m);
        logic signed [DATA_W:0] d;
        d = $signed({p[DATA_W-1], p}) - $signed({m[DATA_W-1], m});
        return d[DATA_W:1];
    endfunction
endpackage

// File: rtl/raster_tracker.sv
// Raster position tracker: follows the (x,y,z) position of the voxel being
// accepted and the bank rotation of the slice store. It flags the voxels
// that complete the stencil of an interior centre.
// Assumes every volume arrives complete, in raster order.
module raster_tracker
    import disp_pkg::*;
#(
    parameter int DIM_X = 4,
    parameter int DIM_Y = 4,
    parameter int DIM_Z = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    output logic [$clog2(DIM_X+1)-1:0]   pos_x,
    output logic [$clog2(DIM_Y+1)-1:0]   pos_y,
    output logic [1:0]                   bank_wr,
    output logic [1:0]                   bank_ctr,
    output logic [1:0]                   bank_bck,
    output logic                         take
);
    localparam int XW = $clog2(DIM_X+1);
    localparam int YW = $clog2(DIM_Y+1);
    localparam int ZW = $clog2(DIM_Z+1);
    localparam logic [XW-1:0] X_LAST = XW'(DIM_X-1);
    localparam logic [YW-1:0] Y_LAST = YW'(DIM_Y-1);
    localparam logic [ZW-1:0] Z_LAST = ZW'(DIM_Z-1);
    localparam logic [XW-1:0] X_HI   = XW'(DIM_X-2);
    localparam logic [YW-1:0] Y_HI   = YW'(DIM_Y-2);
    localparam logic [ZW-1:0] Z_LO   = ZW'(2);

    logic [ZW-1:0] pos_z;

    // Advance the raster position and the slice-bank pointer per voxel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_x   <= '0;
            pos_y   <= '0;
            pos_z   <= '0;
            bank_wr <= 2'd0;
        end else if (in_valid) begin
            if (pos_x == X_LAST) begin
                pos_x <= '0;
                if (pos_y == Y_LAST) begin
                    pos_y <= '0;
                    if (pos_z == Z_LAST) begin
                        pos_z   <= '0;
                        bank_wr <= 2'd0;
                    end else begin
                        pos_z   <= pos_z + 1'b1;
                        bank_wr <= (bank_wr == 2'd2) ? 2'd0 : bank_wr + 2'd1;
                    end
                end else begin
                    pos_y <= pos_y + 1'b1;
                end
            end else begin
                pos_x <= pos_x + 1'b1;
            end
        end
    end

    // Centre slice is one behind the write bank, back slice two behind
    always_comb begin
        bank_ctr = (bank_wr == 2'd0) ? 2'd2 : bank_wr - 2'd1;
        bank_bck = (bank_wr == 2'd2) ? 2'd0 : bank_wr + 2'd1;
    end

    // Incoming voxel is the +z neighbour of an interior centre
    assign take = in_valid && (pos_z >= Z_LO)
                && (pos_x != '0) && (pos_x <= X_HI)
                && (pos_y != '0) && (pos_y <= Y_HI);

    // R1: a row ends after DIM_X accepted voxels
    assert_row_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pos_x == X_LAST) |=> (pos_x == '0));

    // R7: the write bank moves on when a slice completes inside a volume
    assert_bank_turn_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pos_x == X_LAST && pos_y == Y_LAST && pos_z != Z_LAST)
        |=> (bank_wr != $past(bank_wr)));

    // R10: the voxel after the last one of a volume is the origin
    assert_volume_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pos_x == X_LAST && pos_y == Y_LAST && pos_z == Z_LAST)
        |=> (pos_y == '0 && pos_z == '0 && bank_wr == 2'd0));
endmodule

// File: rtl/slice_store.sv
// Three-bank slice store: each bank holds one z-slice of displacement and
// velocity. The incoming voxel is written to the current bank. The seven
// stencil taps of the centre one slice behind are read from the other two
// banks and registered.
// Assumes the tracker hands out three distinct bank indices.
module slice_store
    import disp_pkg::*;
#(
    parameter int DIM_X = 4,
    parameter int DIM_Y = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  cell_t                        wr_cell,
    input  logic [$clog2(DIM_X+1)-1:0]   pos_x,
    input  logic [$clog2(DIM_Y+1)-1:0]   pos_y,
    input  logic [1:0]                   bank_wr,
    input  logic [1:0]                   bank_ctr,
    input  logic [1:0]                   bank_bck,
    input  logic                         take,
    output taps_t                        taps_q,
    output logic                         taps_vld
);
    localparam int CELLS = DIM_X * DIM_Y;
    localparam int AW    = $clog2(CELLS);
    localparam int XW    = $clog2(DIM_X+1);
    localparam int YW    = $clog2(DIM_Y+1);
    localparam logic [AW-1:0] X_STEP = AW'(DIM_X);
    localparam logic [XW-1:0] X_LAST = XW'(DIM_X-1);
    localparam logic [YW-1:0] Y_LAST = YW'(DIM_Y-1);

    logic [AW-1:0] a_c, a_xp, a_xm, a_yp, a_ym;
    cell_t [2:0]   rd_c, rd_xp, rd_xm, rd_yp, rd_ym;

    // Addresses of centre and in-slice neighbours, clamped at the border
    always_comb begin
        a_c  = AW'(pos_y) * X_STEP + AW'(pos_x);
        a_xp = (pos_x == X_LAST) ? a_c : a_c + 1'b1;
        a_xm = (pos_x == '0)     ? a_c : a_c - 1'b1;
        a_yp = (pos_y == Y_LAST) ? a_c : a_c + X_STEP;
        a_ym = (pos_y == '0)     ? a_c : a_c - X_STEP;
    end

    for (genvar b = 0; b < 3; b++) begin : g_bank
        cell_t mem [CELLS];

        // Write the incoming voxel when this bank holds the newest slice
        always_ff @(posedge clk) begin
            if (wr_en && bank_wr == 2'(b)) begin
                mem[a_c] <= wr_cell;
            end
        end

        assign rd_c[b]  = mem[a_c];
        assign rd_xp[b] = mem[a_xp];
        assign rd_xm[b] = mem[a_xm];
        assign rd_yp[b] = mem[a_yp];
        assign rd_ym[b] = mem[a_ym];
    end

    // Register the taps of the centre selected by the bank rotation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taps_vld <= 1'b0;
        end else begin
            taps_vld <= take;
        end
        taps_q.c  <= rd_c[bank_ctr].u;
        taps_q.xp <= rd_xp[bank_ctr].u;
        taps_q.xm <= rd_xm[bank_ctr].u;
        taps_q.yp <= rd_yp[bank_ctr].u;
        taps_q.ym <= rd_ym[bank_ctr].u;
        taps_q.zm <= rd_c[bank_bck].u;
        taps_q.zp <= wr_cell.u;
        taps_q.vc <= rd_c[bank_ctr].v;
    end

    // R7: the written bank never coincides with a bank being read
    assert_bank_apart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (bank_wr != bank_ctr && bank_wr != bank_bck && bank_ctr != bank_bck));
endmodule

// File: rtl/euler_core.sv
// Euler update datapath: from registered stencil taps it forms the halved
// central differences, the transport-corrected rate and the new displacement.
// The result is registered. Assumes dt is held stable by the user.
module euler_core
    import disp_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  taps_t  taps,
    input  logic   taps_vld,
    input  fx_t    dt,
    output logic   out_valid,
    output vec_t   out_u
);
    vec_t nxt_v;

    for (genvar i = 0; i < 3; i++) begin : g_comp
        fx_t gx, gy, gz, acc, rate, nxt;

        // Gradient, rate and stepped value of component i
        always_comb begin
            gx   = half_diff(taps.xp[i], taps.xm[i]);
            gy   = half_diff(taps.yp[i], taps.ym[i]);
            gz   = half_diff(taps.zp[i], taps.zm[i]);
            acc  = fx_mul(taps.vc[0], gx) + fx_mul(taps.vc[1], gy) + fx_mul(taps.vc[2], gz);
            rate = taps.vc[i] - acc;
            nxt  = taps.c[i] + fx_mul(dt, rate);
        end
        assign nxt_v[i] = nxt;
    end

    // Register the updated voxel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_u     <= '0;
        end else begin
            out_valid <= taps_vld;
            if (taps_vld) begin
                out_u <= nxt_v;
            end
        end
    end

    // R6: a zero timestep returns the centre displacement unchanged
    assert_dt_zero_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (taps_vld && dt == '0) |=> (out_u == $past(taps.c)));
endmodule

// File: rtl/disp_euler_top.sv
// Streaming displacement updater: tracks the raster position, buffers three
// slices and applies one explicit Euler step to every interior voxel.
// Assumes complete volumes in raster order and a constant dt.
module disp_euler_top
    import disp_pkg::*;
#(
    parameter int DIM_X = 4,
    parameter int DIM_Y = 4,
    parameter int DIM_Z = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_u0,
    input  logic signed [DATA_W-1:0] in_u1,
    input  logic signed [DATA_W-1:0] in_u2,
    input  logic signed [DATA_W-1:0] in_v0,
    input  logic signed [DATA_W-1:0] in_v1,
    input  logic signed [DATA_W-1:0] in_v2,
    input  logic signed [DATA_W-1:0] dt,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_u0,
    output logic signed [DATA_W-1:0] out_u1,
    output logic signed [DATA_W-1:0] out_u2
);
    logic [$clog2(DIM_X+1)-1:0] pos_x;
    logic [$clog2(DIM_Y+1)-1:0] pos_y;
    logic [1:0]                 bank_wr, bank_ctr, bank_bck;
    logic                       take, taps_vld;
    cell_t                      wr_cell;
    taps_t                      taps;
    vec_t                       out_vec;

    assign wr_cell.u = {in_u2, in_u1, in_u0};
    assign wr_cell.v = {in_v2, in_v1, in_v0};

    raster_tracker #(.DIM_X(DIM_X), .DIM_Y(DIM_Y), .DIM_Z(DIM_Z)) u_track (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .pos_x(pos_x), .pos_y(pos_y),
        .bank_wr(bank_wr), .bank_ctr(bank_ctr), .bank_bck(bank_bck),
        .take(take)
    );

    slice_store #(.DIM_X(DIM_X), .DIM_Y(DIM_Y)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(in_valid), .wr_cell(wr_cell),
        .pos_x(pos_x), .pos_y(pos_y),
        .bank_wr(bank_wr), .bank_ctr(bank_ctr), .bank_bck(bank_bck),
        .take(take), .taps_q(taps), .taps_vld(taps_vld)
    );

    euler_core u_core (
        .clk(clk), .rst_n(rst_n), .taps(taps), .taps_vld(taps_vld),
        .dt(dt), .out_valid(out_valid), .out_u(out_vec)
    );

    assign out_u0 = out_vec[0];
    assign out_u1 = out_vec[1];
    assign out_u2 = out_vec[2];

    // R2: every output traces back to an input accepted two cycles earlier
    assert_out_from_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));
endmodule

// File: tb/tb_disp_euler_top.sv
module tb_disp_euler_top;
    localparam int DX   = 4;
    localparam int DY   = 4;
    localparam int DZ   = 5;
    localparam int NOUT = (DX-2)*(DY-2)*(DZ-2);
    localparam int NPS  = (DX-2)*(DY-2);

    typedef struct packed {
        int dtv;
        int seed;
        int gap;
    } case_t;
    // dt, seed, idle cycle after every gap voxels (0 = none)
    localparam case_t CASES [4] = '{
        '{1024, 1, 0}, '{256, 2, 3}, '{-512, 3, 1}, '{1536, 4, 0}
    };

    logic clk = 1'b0;
    logic rst_n;
    logic in_valid;
    logic signed [31:0] in_u0, in_u1, in_u2, in_v0, in_v1, in_v2, dt;
    logic out_valid;
    logic signed [31:0] out_u0, out_u1, out_u2;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int out_cnt = 0;
    int exp_u [3][NOUT];
    int exp_cyc [NOUT];
    string val_tag = "R5";
    bit done = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    disp_euler_top #(.DIM_X(DX), .DIM_Y(DY), .DIM_Z(DZ)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_u0(in_u0), .in_u1(in_u1), .in_u2(in_u2),
        .in_v0(in_v0), .in_v1(in_v1), .in_v2(in_v2),
        .dt(dt), .out_valid(out_valid),
        .out_u0(out_u0), .out_u1(out_u1), .out_u2(out_u2)
    );

    task automatic chk(input string req, input longint act, input longint expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int ufield(int i, int x, int y, int z, int seed);
        return ((x*731 + y*97 + z*13 + i*29 + seed*71) % 4096) - 2048;
    endfunction

    function automatic int vfield(int i, int x, int y, int z, int seed);
        return ((x*53 + y*389 + z*211 + i*17 + seed*43) % 2048) - 1024;
    endfunction

    function automatic int fmul(int a, int b);
        return int'((longint'(a) * longint'(b)) >>> 10);
    endfunction

    // Independent model of one updated component
    function automatic int model(int i, int x, int y, int z, int seed, int dtv);
        int g [3];
        int acc, r;
        // R3: halved central difference with floor rounding
        g[0] = int'((longint'(ufield(i,x+1,y,z,seed)) - ufield(i,x-1,y,z,seed)) >>> 1);
        g[1] = int'((longint'(ufield(i,x,y+1,z,seed)) - ufield(i,x,y-1,z,seed)) >>> 1);
        g[2] = int'((longint'(ufield(i,x,y,z+1,seed)) - ufield(i,x,y,z-1,seed)) >>> 1);
        // R4: rate with truncated products
        acc = 0;
        for (int a = 0; a < 3; a++) acc = int'(longint'(acc) + fmul(vfield(a,x,y,z,seed), g[a]));
        r = int'(longint'(vfield(i,x,y,z,seed)) - acc);
        // R5: Euler step
        return int'(longint'(ufield(i,x,y,z,seed)) + fmul(dtv, r));
    endfunction

    // Output monitor, sampled away from the rising edge
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (out_cnt < NOUT) begin
                string tg;
                tg = (val_tag == "R5" && out_cnt >= 2*NPS) ? "R7" : val_tag;
                chk(tg, out_u0, exp_u[0][out_cnt]);
                chk(tg, out_u1, exp_u[1][out_cnt]);
                chk(tg, out_u2, exp_u[2][out_cnt]);
                chk("R2", cyc, exp_cyc[out_cnt]);
            end else begin
                chk("R1", out_cnt, NOUT - 1);
            end
            out_cnt++;
        end
    end

    task automatic run_volume(input int seed, input int dtv, input int gap);
        int idx;
        dt = dtv;
        out_cnt = 0;
        for (int z = 1; z < DZ-1; z++)
            for (int y = 1; y < DY-1; y++)
                for (int x = 1; x < DX-1; x++) begin
                    int k;
                    k = ((z-1)*(DY-2) + (y-1))*(DX-2) + (x-1);
                    for (int i = 0; i < 3; i++) exp_u[i][k] = model(i, x, y, z, seed, dtv);
                    exp_cyc[k] = -1;
                end
        idx = 0;
        for (int z = 0; z < DZ; z++)
            for (int y = 0; y < DY; y++)
                for (int x = 0; x < DX; x++) begin
                    @(negedge clk);
                    in_valid = 1'b1;
                    in_u0 = ufield(0,x,y,z,seed); in_u1 = ufield(1,x,y,z,seed);
                    in_u2 = ufield(2,x,y,z,seed); in_v0 = vfield(0,x,y,z,seed);
                    in_v1 = vfield(1,x,y,z,seed); in_v2 = vfield(2,x,y,z,seed);
                    if (z >= 2 && x >= 1 && x <= DX-2 && y >= 1 && y <= DY-2)
                        exp_cyc[((z-2)*(DY-2) + (y-1))*(DX-2) + (x-1)] = cyc + 2;
                    idx++;
                    if (gap > 0 && (idx % gap) == 0) begin
                        // R9: idle cycle with junk data
                        @(negedge clk);
                        in_valid = 1'b0;
                        in_u0 = 32'sh5A5A1234; in_u1 = -32'sd77777; in_u2 = 32'sh7FFFFFFF;
                        in_v0 = -32'sd9999;    in_v1 = 32'sh1234;   in_v2 = 32'sh40000000;
                    end
                end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1", out_cnt, NOUT);
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; dt = '0;
        in_u0 = '0; in_u1 = '0; in_u2 = '0; in_v0 = '0; in_v1 = '0; in_v2 = '0;
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8", out_valid, 0);
        chk("R8", out_u0, 0);
        chk("R8", out_u2, 0);
        rst_n = 1'b1;

        // Vector table, volumes back to back without reset
        for (int c = 0; c < 4; c++) begin
            val_tag = (CASES[c].gap > 0) ? "R9" : ((c > 0) ? "R10" : "R5");
            run_volume(CASES[c].seed, CASES[c].dtv, CASES[c].gap);
        end

        // R6: zero timestep
        val_tag = "R6";
        run_volume(5, 0, 0);

        // R8: reset in mid-volume, then a full volume from the origin
        for (int n = 0; n < 30; n++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_u0 = 32'sd999; in_u1 = -32'sd999; in_u2 = 32'sd5;
            in_v0 = 32'sd300; in_v1 = 32'sd300;  in_v2 = -32'sd300;
        end
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R8", out_valid, 0);
        rst_n = 1'b1;
        val_tag = "R8";
        run_volume(6, 768, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule